// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block watches a stream of memory requests and keeps, for each requesting context, at most one reservation: a granule address recorded by a load-reserved operation. A store-conditional succeeds only if its own context still holds a reservation on the same granule. Any store that is allowed to write removes every reservation on its granule, whoever owns it. Each owner that loses a reservation because a different requester wrote the granule gets a one-cycle clear-exclusive pulse. Addresses are compared at granule level. The low `GRAN_LG` offset bits are dropped before anything is stored or compared.

Requests arrive on a valid/ready channel. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. On that same edge the reservation table is updated and a response is registered. The response is held on `rsp_valid`/`rsp_ok` until the consumer takes it with `rsp_ready`. `req_ready` is high when no response is pending or when the pending one is being taken in the same cycle. A stalled response therefore back-pressures the request side, and no request is lost or reordered. The clear-exclusive vector is a plain status output and is not held by back-pressure.

Operation codes on `req_op` are: 0 plain load, 1 load-reserved, 2 plain store, 3 store-conditional.

Top module: `resv_monitor`

## Requirements
- R1: Addresses are compared and stored at granule level. Two addresses that differ only in bits below `GRAN_LG` (3 by default, an 8-byte granule) are the same reservation.
- R2: A context holds at most one reservation. A load-reserved (op 1) from a context records the new granule and replaces any earlier reservation of that context.
- R3: A store-conditional (op 3) reports `rsp_ok`=1 only if its context holds a valid reservation on the request granule. Otherwise it reports 0.
- R4: A failed store-conditional changes no reservation, including the requester's own reservation on another granule.
- R5: An allowed store (plain store, or a successful store-conditional) invalidates every reservation on that granule in all contexts.
- R6: `clr_excl[k]` pulses high for exactly the cycle after acceptance when context k's reservation was invalidated by a request from a different context. It is never raised for the requester itself.
- R7: A plain load (op 0) changes no reservation and reports `rsp_ok`=0. A load-reserved also reports 0. A plain store (op 2) always reports `rsp_ok`=1.
- R8: A request whose context ID is `NUM_CTX` or more is handled as a plain store whatever its op. It reports `rsp_ok`=1, invalidates all reservations on the granule and notifies every owner that loses one.
- R9: Synchronous reset clears every reservation, `rsp_valid` and `clr_excl`.
- R10: The response appears on the edge that accepts the request. While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_ok` holds. Without a new request, `rsp_valid` falls on the edge where the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 load, 1 load-reserved, 2 store, 3 store-conditional |
| req_ctx | input | CID_W | Requesting context ID |
| req_addr | input | ADDR_W | Physical byte address |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ok | output | 1 | Store-conditional success / store allowed |
| clr_excl | output | NUM_CTX | One-cycle clear-exclusive pulse per owner context |

## Verification
The assertions assume that the request fields are stable and known whenever `req_valid` is high. They also assume that `rsp_ready` and `req_valid` are driven by the environment and not derived combinationally from `req_ready`. The bench changes all inputs only on the falling clock edge and holds a stalled request unchanged until it is accepted. It keeps context IDs within the 3-bit field, using ID 5 as the out-of-range case.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD       = 2'd0,
    OP_LOAD_RSV   = 2'd1,
    OP_STORE      = 2'd2,
    OP_STORE_COND = 2'd3
  } resv_op_e;
endpackage

// File: rtl/resv_entry.sv
// One reservation slot: valid bit plus granule tag, with a match output.
module resv_entry #(
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             kill_en,
  input  logic [TAG_W-1:0] new_tag,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             hit_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else if (load_en) begin
      vld_q <= 1'b1;
      tag_q <= new_tag;
    end else if (kill_en) begin
      vld_q <= 1'b0;
    end
  end

  assign hit_o = vld_q && (tag_q == cmp_tag);
endmodule

// File: rtl/resv_decide.sv
// Combinational verdict: which slots load, which die, who is notified.
module resv_decide
  import resv_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CID_W   = 3
) (
  input  logic               acc,
  input  logic [1:0]         op,
  input  logic [CID_W-1:0]   ctx,
  input  logic [NUM_CTX-1:0] hit,
  output logic [NUM_CTX-1:0] load_en,
  output logic [NUM_CTX-1:0] kill_en,
  output logic [NUM_CTX-1:0] notify,
  output logic               ok
);
  localparam int NC = NUM_CTX;

  logic [NUM_CTX-1:0] sel;
  logic               ctx_in_range;
  logic               own_hit;
  resv_op_e           eff_op;
  logic               allow;

  assign ctx_in_range = (32'(ctx) < NC);

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_sel
    assign sel[k] = ctx_in_range && (ctx == CID_W'(k));
  end

  assign own_hit = |(sel & hit);

  always_comb begin
    eff_op = ctx_in_range ? resv_op_e'(op) : OP_STORE;
    allow  = (eff_op == OP_STORE) || ((eff_op == OP_STORE_COND) && own_hit);
    load_en = (acc && (eff_op == OP_LOAD_RSV)) ? sel : '0;
    kill_en = (acc && allow) ? hit : '0;
    notify  = kill_en & ~sel;
    ok      = allow;
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CID_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [CID_W-1:0]   req_ctx,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_ok,
  output logic [NUM_CTX-1:0] clr_excl
);
  localparam int TAG_W = ADDR_W - GRAN_LG;

  logic               acc;
  logic [TAG_W-1:0]   req_tag;
  logic               unused_offset;
  logic [NUM_CTX-1:0] hit;
  logic [NUM_CTX-1:0] load_en;
  logic [NUM_CTX-1:0] kill_en;
  logic [NUM_CTX-1:0] notify;
  logic               ok;

  assign req_ready     = !rsp_valid || rsp_ready;
  assign acc           = req_valid && req_ready;
  assign req_tag       = req_addr[ADDR_W-1:GRAN_LG];
  assign unused_offset = ^req_addr[GRAN_LG-1:0];

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_slot
    resv_entry #(.TAG_W(TAG_W)) u_entry (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en[k]),
      .kill_en (kill_en[k]),
      .new_tag (req_tag),
      .cmp_tag (req_tag),
      .hit_o   (hit[k])
    );
  end

  resv_decide #(.NUM_CTX(NUM_CTX), .CID_W(CID_W)) u_decide (
    .acc     (acc),
    .op      (req_op),
    .ctx     (req_ctx),
    .hit     (hit),
    .load_en (load_en),
    .kill_en (kill_en),
    .notify  (notify),
    .ok      (ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      clr_excl  <= '0;
    end else begin
      clr_excl <= notify;
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= ok;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int CID_W   = 3,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_op,
  input logic [CID_W-1:0]   req_ctx,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_ok,
  input logic [NUM_CTX-1:0] clr_excl
);
  localparam int NC = NUM_CTX;
  logic acc;
  logic in_range;
  logic unused_addr;
  assign acc         = req_valid && req_ready;
  assign in_range    = (32'(req_ctx) < NC);
  assign unused_addr = ^req_addr;

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rsp_valid && clr_excl == '0));

  p_resp_r10: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);

  p_stall_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ok)));

  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (clr_excl == '0));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && in_range && (req_op == 2'd0 || req_op == 2'd1)) |=> (!rsp_ok && clr_excl == '0));

  p_store_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd2) |=> rsp_ok);

  p_bad_ctx_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_range) |=> rsp_ok);

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_self
    p_no_self_r6: assert property (@(posedge clk) disable iff (rst)
      (acc && req_ctx == CID_W'(k)) |=> !clr_excl[k]);
  end
endmodule

bind resv_monitor resv_monitor_chk #(
  .NUM_CTX(NUM_CTX), .CID_W(CID_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_ctx(req_ctx), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
  .clr_excl(clr_excl)
);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;
  localparam int NUM_CTX = 4;
  localparam int CID_W   = 3;
  localparam int ADDR_W  = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [1:0]         req_op = 2'd0;
  logic [CID_W-1:0]   req_ctx = '0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic               rsp_valid;
  logic               rsp_ready = 1'b1;
  logic               rsp_ok;
  logic [NUM_CTX-1:0] clr_excl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  resv_monitor #(.NUM_CTX(NUM_CTX), .CID_W(CID_W), .ADDR_W(ADDR_W), .GRAN_LG(3)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ctx(req_ctx), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .clr_excl(clr_excl)
  );

  // {op[1:0], ctx[2:0], addr[15:0], exp_ok, exp_clr[3:0]}
  localparam int NV = 29;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 3'd0, 16'h0100, 1'b0, 4'h0},  // R2 reserve
    {2'd3, 3'd0, 16'h0104, 1'b1, 4'h0},  // R1 same granule, R3 success
    {2'd3, 3'd0, 16'h0100, 1'b0, 4'h0},  // R5 own reservation gone
    {2'd1, 3'd1, 16'h0200, 1'b0, 4'h0},
    {2'd1, 3'd2, 16'h0200, 1'b0, 4'h0},
    {2'd1, 3'd3, 16'h0300, 1'b0, 4'h0},
    {2'd3, 3'd1, 16'h0300, 1'b0, 4'h0},  // R3 wrong granule
    {2'd3, 3'd1, 16'h0200, 1'b1, 4'h4},  // R5 R6 ctx2 notified
    {2'd3, 3'd2, 16'h0200, 1'b0, 4'h0},  // R5 ctx2 lost it
    {2'd1, 3'd0, 16'h0400, 1'b0, 4'h0},
    {2'd1, 3'd0, 16'h0500, 1'b0, 4'h0},  // R2 overwrite
    {2'd3, 3'd0, 16'h0400, 1'b0, 4'h0},  // R2 old granule dropped
    {2'd3, 3'd0, 16'h0500, 1'b1, 4'h0},  // R4 kept after failed SC
    {2'd2, 3'd0, 16'h0304, 1'b1, 4'h8},  // R5 R6 R7 plain store
    {2'd3, 3'd3, 16'h0300, 1'b0, 4'h0},
    {2'd1, 3'd1, 16'h0600, 1'b0, 4'h0},
    {2'd0, 3'd2, 16'h0600, 1'b0, 4'h0},  // R7 plain load
    {2'd3, 3'd1, 16'h0600, 1'b1, 4'h0},  // R7 load left it
    {2'd1, 3'd0, 16'h0700, 1'b0, 4'h0},
    {2'd1, 3'd1, 16'h0700, 1'b0, 4'h0},
    {2'd1, 3'd5, 16'h0700, 1'b1, 4'h3},  // R8 bad ctx as store
    {2'd3, 3'd0, 16'h0700, 1'b0, 4'h0},  // R8 wiped
    {2'd1, 3'd2, 16'h0800, 1'b0, 4'h0},
    {2'd2, 3'd2, 16'h0800, 1'b1, 4'h0},  // R6 no self notify
    {2'd3, 3'd2, 16'h0800, 1'b0, 4'h0},
    {2'd1, 3'd3, 16'h0900, 1'b0, 4'h0},
    {2'd3, 3'd1, 16'h0900, 1'b0, 4'h0},  // R4 foreign failed SC
    {2'd3, 3'd3, 16'h0900, 1'b1, 4'h0},  // R4 owner still reserved
    {2'd2, 3'd1, 16'h0A00, 1'b1, 4'h0}   // R7 store with no reservation
  };

  task automatic check(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(input logic [1:0] op, input logic [CID_W-1:0] ctx,
                      input logic [ADDR_W-1:0] addr);
    req_valid = 1'b1;
    req_op    = op;
    req_ctx   = ctx;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!rsp_valid && clr_excl == '0 && req_ready, "R9 reset outputs",
          {rsp_valid, clr_excl, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][25:24], VEC[i][23:21], {16'h0, VEC[i][20:5]});
      check(rsp_valid && rsp_ok == VEC[i][4] && clr_excl == VEC[i][3:0],
            $sformatf("R3/R5/R6 vector %0d", i),
            {rsp_valid, 3'b0, rsp_ok, clr_excl}, {4'h1, 3'b0, VEC[i][4], VEC[i][3:0]});
    end
    @(negedge clk);
    check(clr_excl == '0, "R6 pulse lasts one cycle", clr_excl, 0);
    check(!rsp_valid, "R10 response taken", rsp_valid, 0);

    // R9: reset mid-run drops a live reservation
    send(2'd1, 3'd1, 32'h0B00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!rsp_valid, "R9 rsp_valid cleared", rsp_valid, 0);
    send(2'd3, 3'd1, 32'h0B00);
    check(rsp_ok == 1'b0, "R9 reservation cleared by reset", rsp_ok, 0);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    send(2'd2, 3'd0, 32'h0C00);
    check(rsp_valid && rsp_ok, "R10 response after accept", {rsp_valid, rsp_ok}, 3);
    check(!req_ready, "R10 ready low while stalled", req_ready, 0);
    req_valid = 1'b1;
    req_op    = 2'd3;
    req_ctx   = 3'd0;
    req_addr  = 32'h0C00;
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid && rsp_ok, "R10 held response not replaced", {rsp_valid, rsp_ok}, 3);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && !rsp_ok, "R10 stalled request accepted on take", {rsp_valid, rsp_ok}, 2);
    @(negedge clk);
    check(!rsp_valid, "R10 valid falls when taken", rsp_valid, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule